// File: doc/BRIEF.md
# Serial Response Frame Receiver

This block takes in one response frame from a target device over a single serial data line. The line is sampled once per serial bit period, at cycles marked by a bit strobe from the surrounding link logic. After a request is accepted, the receiver looks for a start bit for a bounded number of bit periods. It then collects a two-bit device identifier and a two-bit response tag.

When the tag reports an acknowledge and the request asked for data, the receiver collects 1, 2 or 4 data bytes. In every case a four-bit check code comes last. The code is verified over the entire frame, start bit included. The frame length therefore depends on the tag that arrives.

When the frame ends, or the start-bit search runs out, the receiver pulses a completion strobe. At the same time it presents the identifier, the tag and the right-aligned data word, with a timeout flag and a check-code error flag. These results hold until the next completion. The line is active low: a low level at a sampling point is a logical one.

Top module: `rsp_rx`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done`, `timeout` and `crc_err` are 0, and `rsp_id`, `rsp_tag` and `rsp_data` are all zero.
- R2: A `start` pulse is accepted only when `busy` is 0. `busy` is then 1 from the next cycle until the frame completes. A `start` while `busy` is 1 is ignored, and so is the `size_code` that comes with it.
- R3: The line is active low: logical bit = NOT `sda_n`. It is sampled only in cycles where `bit_stb` is 1, and its level in other cycles has no effect.
- R4: The start-bit search examines at most HUNT_LIMIT samples (default 1000). A logical 1 at any of these samples, including the last one, is taken as the start bit. If all HUNT_LIMIT samples are logical 0, the frame completes with `timeout`=1, `crc_err`=0 and zero identifier, tag and data.
- R5: The four samples after the start bit are the identifier (2 bits) and then the tag (2 bits), each most significant bit first.
- R6: A data field follows the header only when the tag equals 0 (acknowledge) and `size_code` is nonzero. `size_code` 0, 1, 2, 3 selects 0, 1, 2, 4 bytes and is captured when `start` is accepted. Otherwise the four check bits follow the header directly.
- R7: `rsp_data` is right-aligned, and the first byte received is the most significant byte of the field. Unused upper bits are zero, and the whole word is zero when there is no data field.
- R8: The check code uses the polynomial x^4+x+1 with initial value 0, fed one bit per sample, first bit first. It runs over the start bit, header, data and the four received check bits. A nonzero result sets `crc_err`=1.
- R9: `done` is a one-cycle pulse in the cycle after the clock edge that samples the last bit of the frame. `busy` is 0 in that cycle. The result outputs change only together with `done` and hold until the next `done`.
- R10: `timeout` and `crc_err` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to receive one frame |
| size_code | input | 2 | Expected data size: 0, 1, 2 or 4 bytes |
| bit_stb | input | 1 | Marks the cycle in which the line is sampled |
| sda_n | input | 1 | Serial data line, active low |
| busy | output | 1 | A frame is being received |
| done | output | 1 | One-cycle completion pulse |
| rsp_id | output | ID_W | Received device identifier |
| rsp_tag | output | TAG_W | Received response tag |
| rsp_data | output | MAX_BYTES*8 | Received data, right-aligned |
| timeout | output | 1 | No start bit within the search window |
| crc_err | output | 1 | Check-code residue was nonzero |

## Verification
Acknowledge frames are sent with every size code. Comparing their data against busy and error tags sent with the same size code shows whether the length of the data field follows the received tag or only the requested size. Two search cases sit on either side of the search bound: HUNT_LIMIT-1 idle samples followed by a start bit, and HUNT_LIMIT idle samples. Between strobes the line is driven to the opposite level, so any sampling outside strobe cycles corrupts the frame. Frames with one check bit flipped, and a `start` issued in the middle of a frame with a different size, separate a correct check-code residue and request locking from a receiver that accepts anything.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HUNT = 3'd1,
    ST_HDR  = 3'd2,
    ST_DATA = 3'd3,
    ST_CRC  = 3'd4
  } rx_state_e;

  localparam int unsigned CHK_W = 4;

  // One serial step of the x^4 + x + 1 check register, first bit first.
  function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] cur,
                                                input logic           din);
    logic fb;
    fb = cur[CHK_W-1] ^ din;
    return {cur[2], cur[1], cur[0] ^ fb, fb};
  endfunction

endpackage

// File: rtl/rsp_rx_rst_sync.sv
module rsp_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rsp_rx_shreg.sv
module rsp_rx_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  // Next value: shift toward the MSB, new bit enters at bit 0.
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == 0) begin : g_lsb
      always_comb begin
        if (clr)     q_d[g] = 1'b0;
        else if (en) q_d[g] = din;
        else         q_d[g] = q[g];
      end
    end else begin : g_up
      always_comb begin
        if (clr)     q_d[g] = 1'b0;
        else if (en) q_d[g] = q[g-1];
        else         q_d[g] = q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr || en) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/rsp_rx_chk4.sv
module rsp_rx_chk4
  import rsp_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CHK_W-1:0] res_nx
);

  logic [CHK_W-1:0] res_q;
  logic [CHK_W-1:0] res_d;

  assign res_nx = chk_step(res_q, din);

  always_comb begin
    if (clr)     res_d = '0;
    else if (en) res_d = res_nx;
    else         res_d = res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (clr || en) begin
      res_q <= res_d;
    end
  end

endmodule

// File: rtl/rsp_rx.sv
module rsp_rx
  import rsp_rx_pkg::*;
#(
  parameter int unsigned HUNT_LIMIT = 1000,
  parameter int unsigned MAX_BYTES  = 4,
  parameter int unsigned ID_W       = 2,
  parameter int unsigned TAG_W      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             size_code,
  input  logic                   bit_stb,
  input  logic                   sda_n,
  output logic                   busy,
  output logic                   done,
  output logic [ID_W-1:0]        rsp_id,
  output logic [TAG_W-1:0]       rsp_tag,
  output logic [MAX_BYTES*8-1:0] rsp_data,
  output logic                   timeout,
  output logic                   crc_err
);

  localparam int unsigned DATA_W = MAX_BYTES * 8;
  localparam int unsigned HDR_W  = ID_W + TAG_W;
  localparam int unsigned CNT_W  = $clog2(DATA_W + HDR_W + CHK_W + 1);
  localparam int unsigned HUNT_W = $clog2(HUNT_LIMIT + 1);

  localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(HUNT_LIMIT - 1);
  localparam logic [CNT_W-1:0]  HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0]  CHK_LAST  = CNT_W'(CHK_W - 1);
  localparam logic [TAG_W-1:0]  TAG_ACK   = '0;

  // Reset: asynchronous assertion, synchronous release.
  logic rst_i_n;

  rsp_rx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Control state.
  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HUNT_W-1:0] hunt_q, hunt_d;
  logic [1:0]        size_q;
  logic              accept;
  logic              fin;
  logic              fin_to;
  logic              rx_bit;
  logic [CNT_W-1:0]  need_bits;
  logic [HDR_W-1:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_now;
  logic [TAG_W-1:0]  tag_now;
  logic [DATA_W-1:0] data_q;
  logic [CHK_W-1:0]  res_nx;
  logic              hdr_en;
  logic              data_en;
  logic              chk_en;

  assign rx_bit  = ~sda_n;
  assign accept  = start && (state_q == ST_IDLE);
  assign hdr_now = {hdr_q[HDR_W-2:0], rx_bit};
  assign tag_now = hdr_now[TAG_W-1:0];

  always_comb begin
    unique case (size_q)
      2'd0:    need_bits = '0;
      2'd1:    need_bits = CNT_W'(8);
      2'd2:    need_bits = CNT_W'(16);
      default: need_bits = CNT_W'(DATA_W);
    endcase
  end

  assign hdr_en  = bit_stb && (state_q == ST_HDR);
  assign data_en = bit_stb && (state_q == ST_DATA);
  assign chk_en  = bit_stb && (((state_q == ST_HUNT) && rx_bit) ||
                               (state_q == ST_HDR) ||
                               (state_q == ST_DATA) ||
                               (state_q == ST_CRC));

  rsp_rx_shreg #(.W(HDR_W)) u_hdr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (accept),
    .en    (hdr_en),
    .din   (rx_bit),
    .q     (hdr_q)
  );

  rsp_rx_shreg #(.W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (accept),
    .en    (data_en),
    .din   (rx_bit),
    .q     (data_q)
  );

  rsp_rx_chk4 u_chk4 (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .clr    (accept),
    .en     (chk_en),
    .din    (rx_bit),
    .res_nx (res_nx)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hunt_d  = hunt_q;
    fin     = 1'b0;
    fin_to  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HUNT;
          hunt_d  = '0;
        end
      end
      ST_HUNT: begin
        if (bit_stb) begin
          if (rx_bit) begin
            state_d = ST_HDR;
            cnt_d   = '0;
          end else if (hunt_q == HUNT_LAST) begin
            state_d = ST_IDLE;
            fin     = 1'b1;
            fin_to  = 1'b1;
          end else begin
            hunt_d = hunt_q + 1'b1;
          end
        end
      end
      ST_HDR: begin
        if (bit_stb) begin
          if (cnt_q == HDR_LAST) begin
            cnt_d = '0;
            if ((tag_now == TAG_ACK) && (need_bits != '0)) state_d = ST_DATA;
            else                                          state_d = ST_CRC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bit_stb) begin
          if (cnt_q == need_bits - 1'b1) begin
            cnt_d   = '0;
            state_d = ST_CRC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (bit_stb) begin
          if (cnt_q == CHK_LAST) begin
            state_d = ST_IDLE;
            fin     = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Result next values, loaded only when a frame finishes.
  logic [ID_W-1:0]   id_d;
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] dat_d;
  logic              ce_d;

  always_comb begin
    id_d  = fin_to ? '0 : hdr_q[HDR_W-1:TAG_W];
    tag_d = fin_to ? '0 : hdr_q[TAG_W-1:0];
    dat_d = fin_to ? '0 : data_q;
    ce_d  = !fin_to && (res_nx != '0);
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hunt_q  <= '0;
      size_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hunt_q  <= hunt_d;
      if (accept) begin
        size_q <= size_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done     <= 1'b0;
      rsp_id   <= '0;
      rsp_tag  <= '0;
      rsp_data <= '0;
      timeout  <= 1'b0;
      crc_err  <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        rsp_id   <= id_d;
        rsp_tag  <= tag_d;
        rsp_data <= dat_d;
        timeout  <= fin_to;
        crc_err  <= ce_d;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/rsp_rx_sva.sv
module rsp_rx_sva #(
  parameter int unsigned ID_W   = 2,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ID_W-1:0]   rsp_id,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [DATA_W-1:0] rsp_data,
  input logic              timeout,
  input logic              crc_err
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rsp_data) && $stable(rsp_id) && $stable(rsp_tag) &&
               $stable(timeout) && $stable(crc_err)));

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout && crc_err));

  a_r7_no_data_unless_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (rsp_tag != '0)) |-> (rsp_data == '0));

  a_r4_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> ((rsp_id == '0) && (rsp_tag == '0) && (rsp_data == '0)));

endmodule

bind rsp_rx rsp_rx_sva #(
  .ID_W   (ID_W),
  .TAG_W  (TAG_W),
  .DATA_W (MAX_BYTES * 8)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rsp_id   (rsp_id),
  .rsp_tag  (rsp_tag),
  .rsp_data (rsp_data),
  .timeout  (timeout),
  .crc_err  (crc_err)
);

// File: tb/rsp_rx_tb.sv
`timescale 1ns/1ps
module rsp_rx_tb;

  localparam int HUNT = 1000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  size_code;
  logic        bit_stb;
  logic        sda_n;
  logic        busy;
  logic        done;
  logic [1:0]  rsp_id;
  logic [1:0]  rsp_tag;
  logic [31:0] rsp_data;
  logic        timeout;
  logic        crc_err;

  int n_run  = 0;
  int n_fail = 0;
  bit exp_busy = 0;

  bit          fq[$];
  bit [1:0]    e_id, e_tag;
  bit [31:0]   e_data;
  bit          e_to, e_ce;

  rsp_rx #(.HUNT_LIMIT(HUNT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .bit_stb(bit_stb), .sda_n(sda_n), .busy(busy), .done(done),
    .rsp_id(rsp_id), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .timeout(timeout), .crc_err(crc_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock; compare the per-cycle model (done, busy) at the falling edge.
  task automatic tick(input bit exp_done);
    @(negedge clk);
    chk("R9 done timing", {63'd0, done}, {63'd0, exp_done});
    chk("R2 busy timing", {63'd0, busy}, {63'd0, exp_busy});
  endtask

  function automatic int crc_run(input int from);
    int c = 0;
    for (int i = from; i < fq.size(); i++) begin
      int fb;
      fb = ((c >> 3) & 1) ^ int'(fq[i]);
      c  = ((c << 1) & 15) ^ (fb != 0 ? 3 : 0);
    end
    return c;
  endfunction

  task automatic build(input int zeros, input bit [1:0] id, input bit [1:0] tag,
                       input bit [1:0] code, input bit [31:0] data, input bit flip);
    int nb;
    int c;
    fq.delete();
    for (int i = 0; i < zeros; i++) fq.push_back(1'b0);
    fq.push_back(1'b1);
    fq.push_back(id[1]);  fq.push_back(id[0]);
    fq.push_back(tag[1]); fq.push_back(tag[0]);
    nb = (code == 2'd3) ? 4 : int'(code);
    if (tag == 2'd0 && nb > 0)
      for (int k = nb * 8 - 1; k >= 0; k--) fq.push_back(data[k]);
    c = crc_run(zeros);
    if (flip) c = c ^ 1;
    for (int k = 3; k >= 0; k--) fq.push_back(((c >> k) & 1) != 0);
    e_id  = id;
    e_tag = tag;
    if (tag == 2'd0 && nb > 0)
      e_data = (nb == 4) ? data : (data & ((32'd1 << (nb * 8)) - 32'd1));
    else
      e_data = 32'd0;
    e_to = 1'b0;
    e_ce = flip;
  endtask

  task automatic build_timeout();
    fq.delete();
    for (int i = 0; i < HUNT; i++) fq.push_back(1'b0);
    e_id = 0; e_tag = 0; e_data = 0; e_to = 1'b1; e_ce = 1'b0;
  endtask

  task automatic run(input string tag_s, input bit [1:0] code, input bit mid_start);
    start = 1'b1; size_code = code;
    exp_busy = 1'b1;
    tick(1'b0);
    start = 1'b0;
    for (int i = 0; i < fq.size(); i++) begin
      bit last;
      last  = (i == fq.size() - 1);
      sda_n = fq[i];              // wrong level outside the strobe (R3)
      tick(1'b0);
      if (mid_start && i == 3) begin
        start = 1'b1; size_code = ~code;
      end
      tick(1'b0);
      start   = 1'b0;
      sda_n   = ~fq[i];           // active-low line
      bit_stb = 1'b1;
      if (last) exp_busy = 1'b0;
      tick(last);
      bit_stb = 1'b0;
    end
    chk({tag_s, " R5 id"},   {62'd0, rsp_id},  {62'd0, e_id});
    chk({tag_s, " R5 tag"},  {62'd0, rsp_tag}, {62'd0, e_tag});
    chk({tag_s, " R7 data"}, {32'd0, rsp_data}, {32'd0, e_data});
    chk({tag_s, " R4 timeout"}, {63'd0, timeout}, {63'd0, e_to});
    chk({tag_s, " R8 crc_err"}, {63'd0, crc_err}, {63'd0, e_ce});
    sda_n = 1'b0;
    tick(1'b0);
    tick(1'b0);
    chk({tag_s, " R9 hold"}, {32'd0, rsp_data}, {32'd0, e_data});
    chk({tag_s, " R10 exclusive"}, {63'd0, timeout & crc_err}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; size_code = 2'd0; bit_stb = 1'b0; sda_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy",  {63'd0, busy},  64'd0);
    chk("R1 done",  {63'd0, done},  64'd0);
    chk("R1 flags", {62'd0, timeout, crc_err}, 64'd0);
    chk("R1 data",  {32'd0, rsp_data}, 64'd0);
    chk("R1 id/tag", {60'd0, rsp_id, rsp_tag}, 64'd0);
    rst_n = 1'b1;
    repeat (4) tick(1'b0);

    build(3, 2'd2, 2'd0, 2'd3, 32'hA5C3_1E77, 1'b0); run("R6 ack4", 2'd3, 1'b0);
    build(0, 2'd1, 2'd0, 2'd1, 32'h0000_005A, 1'b0); run("R6 ack1", 2'd1, 1'b0);
    build(5, 2'd3, 2'd0, 2'd2, 32'h0000_BEEF, 1'b0); run("R7 ack2", 2'd2, 1'b0);
    build(1, 2'd0, 2'd0, 2'd0, 32'hFFFF_FFFF, 1'b0); run("R6 ack0", 2'd0, 1'b0);
    build(2, 2'd1, 2'd1, 2'd3, 32'h1234_5678, 1'b0); run("R6 busytag", 2'd3, 1'b0);
    build(0, 2'd2, 2'd2, 2'd2, 32'h0000_CAFE, 1'b0); run("R6 tag2", 2'd2, 1'b0);
    build(4, 2'd3, 2'd3, 2'd1, 32'h0000_0011, 1'b0); run("R6 tag3", 2'd1, 1'b0);
    build(0, 2'd1, 2'd0, 2'd3, 32'hDEAD_BEEF, 1'b1); run("R8 flip4", 2'd3, 1'b0);
    build(2, 2'd2, 2'd1, 2'd0, 32'h0, 1'b1);         run("R8 flipnodata", 2'd0, 1'b0);
    build(HUNT - 1, 2'd3, 2'd0, 2'd1, 32'h0000_00C3, 1'b0); run("R4 edge", 2'd1, 1'b0);
    build_timeout();                                   run("R4 timeout", 2'd2, 1'b0);
    build(0, 2'd2, 2'd0, 2'd1, 32'h0000_0096, 1'b0); run("R2 midstart", 2'd1, 1'b1);
    build(1, 2'd0, 2'd0, 2'd2, 32'h0000_7E81, 1'b0); run("R3 after", 2'd2, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule